// File: doc/BRIEF.md
# I2C Read-Transfer Target with Input Glitch Filtering

This block is a target on a two-wire I2C bus that answers read transfers from a controller. Both bus lines are first brought into the system clock domain through a two-stage synchronizer. Each line then passes through a filter that accepts a new level only after it has held for three system clocks. START and STOP conditions are recognised on the filtered lines. The first byte of a transfer is compared against a bank of programmable own addresses, each with its own enable, and against the general call address. A match raises an interrupt request and records which entry hit.

For a read, the block sends bytes from a single host-loaded data buffer, most significant bit first. After each byte it samples the controller's acknowledge. An ACK asks for another byte. A NACK ends the data phase, and the block then stays off the bus until the next STOP or repeated START. If the buffer is empty when the next byte is due, the block holds SCL low until the host loads a byte. Writes addressed to the block are acknowledged at the address stage only. No data is taken in.

Top module: `i2c_rd_target`

## Requirements
- R1: A pulse on SCL or SDA that lasts fewer than three system clocks leaves the filtered level unchanged. A pulse of three clocks or more is accepted.
- R2: After reset, and after any STOP, both open-drain enables are low. A START, including a repeated START, always begins reception of a new address byte.
- R3: The address byte is received MSB first: seven address bits, then the direction bit (1 = read). It matches an own-address entry when that entry's enable is 1 and the address is equal and nonzero. When several entries match, the lowest index is reported. A matched address is acknowledged by driving SDA low through the ninth SCL pulse. An unmatched or disabled address is not acknowledged.
- R4: Address 7'h00 with direction 0 is a general call. It is acknowledged and flagged. Address 7'h00 with direction 1 is not acknowledged.
- R5: `irq_o` rises after an address match and stays high until `irq_clr_i` is pulsed. A transfer that is not matched does not raise it.
- R6: On a match, `stat_idx_o` takes the matching entry's index, `stat_gc_o` is set to 1 for a general call, `stat_dir_o` takes the direction bit, and `stat_nack_o` is cleared. `stat_nack_o` then holds the controller's last acknowledge bit (1 = NACK).
- R7: In a read, each byte loaded through `tx_data_i`/`tx_load_i` is sent MSB first. `sda_oe_o` changes only while the filtered SCL is low.
- R8: An ACK from the controller leads to the next byte. After a NACK, SDA stays released and all further SCL pulses are ignored until STOP or a repeated START.
- R9: If no byte is loaded when SCL falls at the end of an acknowledge pulse in a read, `scl_oe_o` holds SCL low until the host loads a byte. The first bit is then driven.
- R10: A write to an own address is acknowledged at the address byte. Its data bytes are not acknowledged, and the block drives nothing until STOP or START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | NADDR*7 | Own addresses; entry i is at bits [7i+6:7i] |
| own_en_i | input | NADDR | Enable for each own-address entry |
| tx_data_i | input | 8 | Next byte to transmit |
| tx_load_i | input | 1 | One-cycle strobe that loads `tx_data_i` into the buffer |
| irq_clr_i | input | 1 | One-cycle strobe that clears the interrupt |
| irq_o | output | 1 | Interrupt request (address matched) |
| stat_idx_o | output | IW = clog2(NADDR) | Index of the matched own address |
| stat_gc_o | output | 1 | Last match was a general call |
| stat_dir_o | output | 1 | Direction bit of the last match |
| stat_nack_o | output | 1 | Last acknowledge bit from the controller (1 = NACK) |

## Verification
The assertions take for granted a well-behaved controller. It never moves SDA while SCL is high except to form START or STOP. It never issues START or STOP while the target holds SDA low. It waits for SCL to read high before timing its high phase. The bench controller model meets these conditions: it changes SDA only several clocks into the SCL low phase, waits out any clock hold, and keeps each bus phase well longer than the filter delay. The only breaks in these rules are the deliberate two- and four-cycle spikes used for the filter checks, and those stay within a single phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_APEND = 3'd2,
    ST_AACK  = 3'd3,
    ST_TX    = 3'd4,
    ST_TACK  = 3'd5,
    ST_HOLD  = 3'd6,
    ST_SKIP  = 3'd7
  } tgt_state_e;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

endpackage

// File: rtl/tgt_line_filter.sv
module tgt_line_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT + 1);

  logic       s1, s2;
  logic       filt_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt    <= '0;
    end else if (s2 == filt_q) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT - 1)) begin
      filt_q <= s2;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign filt_o = filt_q;

  generate
    if (FILT >= 3) begin : g_chk
      AST_FILT_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(s2, 1) == filt_q && $past(s2, 2) == filt_q &&
                              $past(s2, 3) == filt_q)); // R1
    end
  endgenerate

endmodule

// File: rtl/tgt_bus_events.sv
module tgt_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_o = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_o  = scl_f & scl_q & ~sda_q & sda_f;
  assign rise_o  = scl_f & ~scl_q;
  assign fall_o  = ~scl_f & scl_q;

endmodule

// File: rtl/tgt_addr_match.sv
module tgt_addr_match #(
  parameter int NADDR = 4,
  localparam int IW = (NADDR > 1) ? $clog2(NADDR) : 1
) (
  input  logic [6:0]         addr_i,
  input  logic               rw_i,
  input  logic [NADDR*7-1:0] own_addr_i,
  input  logic [NADDR-1:0]   own_en_i,
  output logic               match_o,
  output logic               gc_o,
  output logic [IW-1:0]      idx_o
);
  logic [NADDR-1:0] hit;

  function automatic logic [IW-1:0] lowest_set(input logic [NADDR-1:0] v);
    lowest_set = '0;
    for (int i = NADDR - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = IW'(i);
    end
  endfunction

  generate
    for (genvar g = 0; g < NADDR; g++) begin : g_cmp
      assign hit[g] = own_en_i[g] && (own_addr_i[g*7 +: 7] == addr_i) && (addr_i != 7'h00);
    end
  endgenerate

  assign gc_o    = (addr_i == 7'h00) && !rw_i;
  assign match_o = (|hit) || gc_o;
  assign idx_o   = lowest_set(hit);

endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
  import i2c_tgt_pkg::*;
#(
  parameter int NADDR = 4,
  parameter int FILT  = 3,
  localparam int IW = (NADDR > 1) ? $clog2(NADDR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  input  logic [NADDR*7-1:0] own_addr_i,
  input  logic [NADDR-1:0]   own_en_i,
  input  logic [7:0]         tx_data_i,
  input  logic               tx_load_i,
  input  logic               irq_clr_i,
  output logic               irq_o,
  output logic [IW-1:0]      stat_idx_o,
  output logic               stat_gc_o,
  output logic               stat_dir_o,
  output logic               stat_nack_o
);
  logic scl_f, sda_f;
  logic bus_start, bus_stop, scl_rise, scl_fall;
  logic am_match, am_gc;
  logic [IW-1:0] am_idx;

  tgt_state_e  st;
  logic [BYTE_W-1:0] shr;
  logic [2:0]  bitc;
  logic        sda_oe_r, scl_oe_r;
  logic [BYTE_W-1:0] tx_buf;
  logic        tx_full;
  logic        irq_r;
  logic [IW-1:0] idx_r;
  logic        gc_r, dir_r, nack_r;

  // named internal events
  logic bus_evt;
  logic match_ev;
  logic fetch_pt;
  logic ack_sample;

  tgt_line_filter #(.FILT(FILT)) i_scl_flt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .filt_o(scl_f));
  tgt_line_filter #(.FILT(FILT)) i_sda_flt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .filt_o(sda_f));

  tgt_bus_events i_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_o(bus_start), .stop_o(bus_stop), .rise_o(scl_rise), .fall_o(scl_fall));

  tgt_addr_match #(.NADDR(NADDR)) i_match (
    .addr_i(shr[6:0]), .rw_i(sda_f), .own_addr_i(own_addr_i), .own_en_i(own_en_i),
    .match_o(am_match), .gc_o(am_gc), .idx_o(am_idx));

  assign bus_evt    = bus_start | bus_stop;
  assign match_ev   = !bus_evt && (st == ST_ADDR) && scl_rise && (bitc == 3'd7) && am_match;
  assign fetch_pt   = !bus_evt && ((scl_fall && ((st == ST_AACK && dir_r) ||
                                                 (st == ST_TACK && !nack_r))) ||
                                   (st == ST_HOLD));
  assign ack_sample = !bus_evt && (st == ST_TACK) && scl_rise;

  // bus state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shr      <= '0;
      bitc     <= '0;
      sda_oe_r <= 1'b0;
      scl_oe_r <= 1'b0;
    end else if (bus_start) begin
      st       <= ST_ADDR;
      bitc     <= '0;
      sda_oe_r <= 1'b0;
      scl_oe_r <= 1'b0;
    end else if (bus_stop) begin
      st       <= ST_IDLE;
      sda_oe_r <= 1'b0;
      scl_oe_r <= 1'b0;
    end else if (fetch_pt) begin
      if (tx_full) begin
        shr      <= {tx_buf[6:0], 1'b0};
        sda_oe_r <= ~tx_buf[7];
        scl_oe_r <= 1'b0;
        bitc     <= '0;
        st       <= ST_TX;
      end else begin
        sda_oe_r <= 1'b0;
        scl_oe_r <= 1'b1;
        st       <= ST_HOLD;
      end
    end else begin
      case (st)
        ST_ADDR: if (scl_rise) begin
          shr  <= {shr[6:0], sda_f};
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) st <= am_match ? ST_APEND : ST_SKIP;
        end
        ST_APEND: if (scl_fall) begin
          sda_oe_r <= 1'b1;
          st       <= ST_AACK;
        end
        ST_AACK: if (scl_fall) begin
          sda_oe_r <= 1'b0;
          st       <= ST_SKIP;
        end
        ST_TX: if (scl_fall) begin
          if (bitc == 3'd7) begin
            sda_oe_r <= 1'b0;
            st       <= ST_TACK;
          end else begin
            sda_oe_r <= ~shr[7];
            shr      <= {shr[6:0], 1'b0};
            bitc     <= bitc + 3'd1;
          end
        end
        ST_TACK: if (scl_fall) st <= ST_SKIP;
        default: ;
      endcase
    end
  end

  // host data buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
    end else if (tx_load_i) begin
      tx_buf  <= tx_data_i;
      tx_full <= 1'b1;
    end else if (fetch_pt && tx_full) begin
      tx_full <= 1'b0;
    end
  end

  // status and interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_r  <= 1'b0;
      idx_r  <= '0;
      gc_r   <= 1'b0;
      dir_r  <= 1'b0;
      nack_r <= 1'b0;
    end else begin
      if (match_ev) irq_r <= 1'b1;
      else if (irq_clr_i) irq_r <= 1'b0;
      if (match_ev) begin
        idx_r  <= am_idx;
        gc_r   <= am_gc;
        dir_r  <= sda_f;
        nack_r <= 1'b0;
      end else if (ack_sample) begin
        nack_r <= sda_f;
      end
    end
  end

  assign sda_oe_o    = sda_oe_r;
  assign scl_oe_o    = scl_oe_r;
  assign irq_o       = irq_r;
  assign stat_idx_o  = idx_r;
  assign stat_gc_o   = gc_r;
  assign stat_dir_o  = dir_r;
  assign stat_nack_o = nack_r;

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_r) |-> $past(match_ev)); // R5
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_r) |-> !$past(scl_f)); // R7
  AST_HOLD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_r) |-> !scl_f); // R9
  AST_NO_GC_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK) |-> !(gc_r && dir_r)); // R4
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> (!sda_oe_r && !scl_oe_r)); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!sda_oe_r && !scl_oe_r)); // R2

endmodule

// File: tb/test_i2c_rd_target.sv
module test_i2c_rd_target;
  localparam int NADDR = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic [NADDR*7-1:0] own_addr = {7'h71, 7'h50, 7'h50, 7'h2A};
  logic [NADDR-1:0]   own_en = 4'b1110;
  logic [7:0] tx_data = 8'h00;
  logic tx_load = 1'b0, irq_clr = 1'b0;
  logic irq;
  logic [IW-1:0] stat_idx;
  logic stat_gc, stat_dir, stat_nack;
  logic scl, sda;

  int n_chk = 0, n_fail = 0, stretch_cnt = 0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  logic [7:0] txb [0:15];

  always #10 clk = ~clk;

  assign scl = scl_m & ~scl_oe;
  assign sda = sda_m & ~sda_oe;

  i2c_rd_target #(.NADDR(NADDR)) i_i2c_rd_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .own_addr_i(own_addr), .own_en_i(own_en),
    .tx_data_i(tx_data), .tx_load_i(tx_load), .irq_clr_i(irq_clr),
    .irq_o(irq), .stat_idx_o(stat_idx), .stat_gc_o(stat_gc),
    .stat_dir_o(stat_dir), .stat_nack_o(stat_nack));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic m_bit(input logic b, input int gscl, input int gsda, output logic r);
    sda_m = b;
    wcyc(7);
    if (gscl > 0) begin
      scl_m = 1'b1; wcyc(gscl); scl_m = 1'b0;
    end
    wcyc(8);
    scl_m = 1'b1;
    wcyc(1);
    while (scl == 1'b0) begin stretch_cnt++; wcyc(1); end
    wcyc(7);
    if (gsda > 0) begin
      sda_m = 1'b0; wcyc(gsda); sda_m = b;
    end
    wcyc(7);
    r = sda;
    wcyc(8);
    scl_m = 1'b0;
    wcyc(4);
  endtask

  task automatic m_start();
    if (scl_m == 1'b0) begin
      sda_m = 1'b1; wcyc(8);
      scl_m = 1'b1; wcyc(1);
      while (scl == 1'b0) wcyc(1);
      wcyc(10);
    end
    sda_m = 1'b0; wcyc(15);
    scl_m = 1'b0; wcyc(4);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wcyc(8);
    scl_m = 1'b1; wcyc(1);
    while (scl == 1'b0) wcyc(1);
    wcyc(10);
    sda_m = 1'b1; wcyc(20);
  endtask

  task automatic m_addr(input logic [6:0] a, input logic rw, input int gscl, input int gsda,
                        output logic ack);
    logic [7:0] v;
    logic r;
    v = {a, rw};
    for (int i = 7; i >= 0; i--) m_bit(v[i], (i == 7) ? gscl : 0, (i == 7) ? gsda : 0, r);
    m_bit(1'b1, 0, 0, r);
    ack = ~r;
  endtask

  task automatic m_read_byte(input bit mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, 0, 0, r);
      d[i] = r;
    end
    m_bit(~mack, 0, 0, r);
  endtask

  task automatic m_write_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], 0, 0, r);
    m_bit(1'b1, 0, 0, r);
    ack = ~r;
  endtask

  // driver: pushes expected bytes, collects observed bytes for the monitor
  task automatic rd_xfer(input logic [6:0] a, input int n, input int base,
                         input bit extra, input bit do_stop);
    logic ack;
    logic [7:0] d;
    host_write(txb[base]);
    m_start();
    m_addr(a, 1'b1, 0, 0, ack);
    chk(ack == 1'b1, "R3 read address acknowledged", ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(txb[base + k]);
      fork
        m_read_byte(k < n - 1, d);
        begin
          if (k + 1 < n) begin
            wcyc(100);
            host_write(txb[base + k + 1]);
          end
        end
      join
      obs_q.push_back(d);
      if (k < n - 1) chk(stat_nack == 1'b0, "R6 ack recorded", stat_nack, 0);
    end
    chk(stat_nack == 1'b1, "R8 nack recorded", stat_nack, 1);
    if (extra) begin
      m_read_byte(1'b0, d);
      chk(d == 8'hFF, "R8 bus ignored after nack", d, 8'hFF);
    end
    if (do_stop) begin
      m_stop();
      chk(!sda_oe && !scl_oe, "R2 lines released after stop", {scl_oe, sda_oe}, 0);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        logic [7:0] e, o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        chk(o == e, "R7 transmitted byte", o, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) txb[i] = 8'(8'h3B * i + 8'h5A);
    txb[0] = 8'hA5; txb[1] = 8'h3C; txb[2] = 8'h81;

    wcyc(5);
    chk(!sda_oe && !scl_oe, "R2 reset released", {scl_oe, sda_oe}, 0);
    chk(irq == 1'b0, "R5 reset irq low", irq, 0);
    rst_n = 1'b1;
    wcyc(10);
    chk(!sda_oe && !scl_oe && !irq, "R2 idle after reset", {irq, scl_oe, sda_oe}, 0);

    // three-byte read to an address held by two entries
    rd_xfer(7'h50, 3, 0, 1'b1, 1'b1);
    chk(irq == 1'b1, "R5 irq after match", irq, 1);
    chk(stat_idx == 2'd1, "R3 lowest matching index", stat_idx, 1);
    chk(stat_dir == 1'b1 && stat_gc == 1'b0, "R6 read direction", {stat_gc, stat_dir}, 1);
    pulse_clr();
    wcyc(2);
    chk(irq == 1'b0, "R5 irq cleared", irq, 0);

    // disabled entry
    m_start();
    m_addr(7'h2A, 1'b1, 0, 0, ack);
    chk(ack == 1'b0, "R3 disabled entry not acknowledged", ack, 0);
    m_stop();
    chk(irq == 1'b0, "R5 no irq without match", irq, 0);

    // general call
    m_start();
    m_addr(7'h00, 1'b1, 0, 0, ack);
    chk(ack == 1'b0, "R4 general call read not acknowledged", ack, 0);
    m_stop();
    m_start();
    m_addr(7'h00, 1'b0, 0, 0, ack);
    chk(ack == 1'b1, "R4 general call write acknowledged", ack, 1);
    chk(stat_gc == 1'b1 && stat_dir == 1'b0, "R6 general call flagged", {stat_gc, stat_dir}, 2);
    m_write_byte(8'h55, ack);
    chk(ack == 1'b0, "R10 write data not acknowledged", ack, 0);
    m_stop();
    pulse_clr();

    // own write
    m_start();
    m_addr(7'h71, 1'b0, 0, 0, ack);
    chk(ack == 1'b1, "R10 own write address acknowledged", ack, 1);
    chk(stat_idx == 2'd3 && stat_dir == 1'b0, "R6 write index and direction", {stat_idx, stat_dir}, 6);
    m_write_byte(8'h0F, ack);
    chk(ack == 1'b0, "R10 own write data not acknowledged", ack, 0);
    m_stop();
    pulse_clr();

    // clock hold with empty buffer
    stretch_cnt = 0;
    m_start();
    m_addr(7'h71, 1'b1, 0, 0, ack);
    chk(ack == 1'b1, "R3 acknowledged before hold", ack, 1);
    exp_q.push_back(8'hC3);
    fork
      m_read_byte(1'b0, d);
      begin
        wcyc(200);
        chk(scl_oe == 1'b1 && scl == 1'b0, "R9 SCL held while buffer empty", scl_oe, 1);
        host_write(8'hC3);
      end
    join
    obs_q.push_back(d);
    chk(stretch_cnt > 150, "R9 hold lasted until load", stretch_cnt, 151);
    m_stop();
    pulse_clr();

    // glitch rejection: 2-cycle spikes on both lines
    host_write(8'h96);
    m_start();
    m_addr(7'h50, 1'b1, 2, 2, ack);
    chk(ack == 1'b1, "R1 short spikes rejected", ack, 1);
    exp_q.push_back(8'h96);
    m_read_byte(1'b0, d);
    obs_q.push_back(d);
    m_stop();
    pulse_clr();

    // 4-cycle SCL pulse is a real clock edge and misaligns the address
    m_start();
    m_addr(7'h50, 1'b1, 4, 0, ack);
    chk(ack == 1'b0, "R1 long pulse accepted as clock", ack, 0);
    m_stop();
    pulse_clr();

    // repeated START after NACK
    rd_xfer(7'h50, 1, 4, 1'b0, 1'b0);
    rd_xfer(7'h71, 2, 6, 1'b0, 1'b1);
    chk(stat_idx == 2'd3, "R2 repeated start selects new address", stat_idx, 3);
    pulse_clr();

    // enabling entry 0
    own_en = 4'b1111;
    rd_xfer(7'h2A, 1, 9, 1'b0, 1'b1);
    chk(stat_idx == 2'd0, "R3 enabled entry matched", stat_idx, 0);

    wcyc(20);
    chk(exp_q.size() == 0 && obs_q.size() == 0, "R7 all bytes observed",
        exp_q.size() + obs_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule